// File: doc/BRIEF.md
# General-Purpose Pin and Event Interrupt Status

This block keeps the status for five general-purpose pins and a bank of event status bits, and builds the 20-bit slot 12 word that goes back to the controller every frame. A pin can be an input or an output, and a direction input selects which for each pin.

For an input pin, the block passes the level through a two-flop synchronizer. It reports that level in slot 12. A change on the synchronized level can latch a sticky pin status bit, but only when the pin's wake mask bit allows it. For an output pin, the block drives the level that the controller placed in its own outgoing slot 12. The block captures that level at a frame boundary and echoes it back one frame later.

Event status bits are set by pulses from outside the block. An event config register qualifies them, and the qualified bits form a summary bit. One interrupt flag combines the unmasked pin status bits and the enabled event status bits. Software clears a source by writing zero to that source's status bit.

Top module: `gpio_evt_status`

## Requirements
- R1: In `slot12`, bits 8..4 carry the GPIO levels, with pin 4 in bit 8 and pin 0 in bit 4. Bit 2 is the event summary and bit 0 is the interrupt flag. Bits 19..9, 3 and 1 are always 0.
- R2: A pin with `pin_dir` bit 0 is an input. Its `slot12` bit shows the value that `pin_in` had two rising clock edges earlier.
- R3: On a clock edge with `frame_strobe` high, `pin_out` loads `ctl_slot12[8:4]`. It holds between strobes. A pin with `pin_dir` bit 1 is an output, and its `slot12` bit shows the `pin_out` value that was in place before the latest strobe. A level set at one frame boundary therefore appears at the next one.
- R4: A pin status bit is set when the synchronized level of an input pin changes while that pin's wake mask bit (register 52h, bits 4..0) is 1. Changes on masked pins and on output pins set nothing.
- R5: A write to register 54h clears each pin status bit whose data bit is 0 and keeps each bit whose data bit is 1. A set and a clear of the same bit in one cycle leave the bit set.
- R6: Each high bit of `evt_set` sets its event status bit. A write to register 7Ah clears each bit whose data bit is 0 and keeps each bit whose data bit is 1. A set wins over a clear in the same cycle.
- R7: The event summary bit is the OR over all event status bits, each ANDed with the matching bit of the config register 70h.
- R8: The interrupt flag is the OR of every pin status bit whose wake mask bit is 1 and every enabled event status bit. It falls only when all of these are cleared.
- R9: A write to any index other than 52h, 54h, 70h and 7Ah changes no state.
- R10: After reset, all status, mask, config, echo and output registers are 0, so `slot12` and `pin_out` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_strobe | input | 1 | One-cycle pulse at each frame boundary |
| ctl_slot12 | input | 20 | Controller's outgoing slot 12; bits 8..4 are the output pin levels |
| pin_in | input | 5 | Raw pin levels |
| pin_dir | input | 5 | Per-pin direction, 1 = output |
| evt_set | input | NEVT | Event status set pulses |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 7 | Register write index |
| wr_data | input | 16 | Register write data |
| pin_out | output | 5 | Driven output pin levels |
| slot12 | output | 20 | Returned slot 12 word |

## Verification
The same status bit can be set and cleared in the same cycle. For a pin, this happens when a synchronized edge lands in the cycle of a zero-write to 54h. For an event, it happens when an `evt_set` pulse coincides with a zero-write to 7Ah. The bench times a pin toggle so that the edge reaches the third register stage exactly when the write arrives, and it fires an event pulse together with a write. In both cases it judges the result through the interrupt and summary bits in the cycles that follow. Random writes and pin toggles create further overlaps, and a cycle-by-cycle bench model checks each one.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int NPINS    = 5;
  localparam int SLOT_W   = 20;
  localparam int IDX_W    = 7;
  localparam int DATA_W   = 16;
  localparam int GPIO_LSB = 4;
  localparam int SUM_BIT  = 2;
  localparam int IRQ_BIT  = 0;

  localparam logic [IDX_W-1:0] IDX_WAKE  = 7'h52;
  localparam logic [IDX_W-1:0] IDX_PSTAT = 7'h54;
  localparam logic [IDX_W-1:0] IDX_ECFG  = 7'h70;
  localparam logic [IDX_W-1:0] IDX_ESTAT = 7'h7A;

  // Assemble the returned slot 12 word; unlisted bits stay zero.
  function automatic logic [SLOT_W-1:0] pack_slot12(
    input logic [NPINS-1:0] gpio,
    input logic             summary,
    input logic             irq
  );
    logic [SLOT_W-1:0] w;
    w = '0;
    w[GPIO_LSB +: NPINS] = gpio;
    w[SUM_BIT]           = summary;
    w[IRQ_BIT]           = irq;
    return w;
  endfunction

  // Pick per pin: echoed output level or synchronized input level.
  function automatic logic [NPINS-1:0] merge_levels(
    input logic [NPINS-1:0] dir_out,
    input logic [NPINS-1:0] echo,
    input logic [NPINS-1:0] sampled
  );
    return (dir_out & echo) | (~dir_out & sampled);
  endfunction
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_raw,
  output logic [N-1:0] lvl,
  output logic [N-1:0] chg
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= pin_raw[i];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign lvl[i] = s2_q;
    assign chg[i] = s2_q ^ s3_q;
  end
endmodule

// File: rtl/sticky_bank.sv
module sticky_bank #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_we,
  input  logic [W-1:0] keep_mask,
  input  logic [W-1:0] set,
  output logic [W-1:0] stat
);
  logic [W-1:0] stat_q;
  logic [W-1:0] kept;

  always_comb kept = clr_we ? (stat_q & keep_mask) : stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= kept | set;
  end

  assign stat = stat_q;
endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status
  import gpio_evt_pkg::*;
#(
  parameter int NEVT = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_strobe,
  input  logic [SLOT_W-1:0]      ctl_slot12,
  input  logic [NPINS-1:0]       pin_in,
  input  logic [NPINS-1:0]       pin_dir,
  input  logic [NEVT-1:0]        evt_set,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [DATA_W-1:0]      wr_data,
  output logic [NPINS-1:0]       pin_out,
  output logic [SLOT_W-1:0]      slot12
);
  localparam int EVT_USED = (NEVT < DATA_W) ? NEVT : DATA_W;

  // Named internal events, also observed by the checker
  logic [NPINS-1:0] pin_lvl, pin_chg, pin_set, pin_stat;
  logic [NEVT-1:0]  evt_stat, evt_keep;
  logic             wake_we, pstat_we, ecfg_we, estat_we;
  logic             evt_sum, irq_flag;

  logic [NPINS-1:0] wake_q, out_q, echo_q;
  logic [NEVT-1:0]  ecfg_q;

  assign wake_we  = wr_en && (wr_idx == IDX_WAKE);
  assign pstat_we = wr_en && (wr_idx == IDX_PSTAT);
  assign ecfg_we  = wr_en && (wr_idx == IDX_ECFG);
  assign estat_we = wr_en && (wr_idx == IDX_ESTAT);

  gpio_pin_sync #(.N(NPINS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_raw (pin_in),
    .lvl     (pin_lvl),
    .chg     (pin_chg)
  );

  assign pin_set = pin_chg & ~pin_dir & wake_q;

  sticky_bank #(.W(NPINS)) u_pin_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_we    (pstat_we),
    .keep_mask (wr_data[NPINS-1:0]),
    .set       (pin_set),
    .stat      (pin_stat)
  );

  always_comb begin
    evt_keep = '1;
    evt_keep[EVT_USED-1:0] = wr_data[EVT_USED-1:0];
  end

  sticky_bank #(.W(NEVT)) u_evt_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_we    (estat_we),
    .keep_mask (evt_keep),
    .set       (evt_set),
    .stat      (evt_stat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q <= '0;
      ecfg_q <= '0;
    end else begin
      if (wake_we) wake_q <= wr_data[NPINS-1:0];
      if (ecfg_we) ecfg_q[EVT_USED-1:0] <= wr_data[EVT_USED-1:0];
    end
  end

  // Output levels load at a frame boundary; the echo trails by one frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      echo_q <= '0;
    end else if (frame_strobe) begin
      out_q  <= ctl_slot12[GPIO_LSB +: NPINS];
      echo_q <= out_q;
    end
  end

  assign evt_sum  = |(evt_stat & ecfg_q);
  assign irq_flag = (|(pin_stat & wake_q)) | evt_sum;

  assign pin_out = out_q;
  assign slot12  = pack_slot12(merge_levels(pin_dir, echo_q, pin_lvl), evt_sum, irq_flag);
endmodule

// File: rtl/gpio_evt_status_chk.sv
module gpio_evt_status_chk
  import gpio_evt_pkg::*;
#(
  parameter int NEVT = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  frame_strobe,
  input logic [SLOT_W-1:0]     ctl_slot12,
  input logic [NPINS-1:0]      pin_out,
  input logic [SLOT_W-1:0]     slot12,
  input logic [NPINS-1:0]      pin_set,
  input logic [NPINS-1:0]      pin_stat,
  input logic                  pstat_we,
  input logic [NEVT-1:0]       evt_set,
  input logic [NEVT-1:0]       evt_stat,
  input logic                  estat_we
);
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (slot12[19:9] == '0) && !slot12[3] && !slot12[1]);

  a_r3_out_load: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |=> (pin_out == $past(ctl_slot12[GPIO_LSB +: NPINS])));

  a_r3_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_strobe |=> $stable(pin_out));

  a_r4_pin_rise_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((pin_stat & ~$past(pin_stat) & ~$past(pin_set)) == '0));

  a_r5_pin_fall_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !pstat_we |=> (($past(pin_stat) & ~pin_stat) == '0));

  a_r5_pin_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((~pin_stat & $past(pin_set)) == '0));

  a_r6_evt_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((~evt_stat & $past(evt_set)) == '0));

  a_r6_evt_fall_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !estat_we |=> (($past(evt_stat) & ~evt_stat) == '0));

  a_r8_summary_implies_irq: assert property (@(posedge clk) disable iff (!rst_n)
    slot12[SUM_BIT] |-> slot12[IRQ_BIT]);
endmodule

bind gpio_evt_status gpio_evt_status_chk #(.NEVT(NEVT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_strobe (frame_strobe),
  .ctl_slot12   (ctl_slot12),
  .pin_out      (pin_out),
  .slot12       (slot12),
  .pin_set      (pin_set),
  .pin_stat     (pin_stat),
  .pstat_we     (pstat_we),
  .evt_set      (evt_set),
  .evt_stat     (evt_stat),
  .estat_we     (estat_we)
);

// File: tb/gpio_evt_status_bench.sv
`timescale 1ns/1ps
module gpio_evt_status_bench;
  localparam int NE = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_strobe = 1'b0;
  logic [19:0] ctl_slot12 = '0;
  logic [4:0]  pin_in = '0;
  logic [4:0]  pin_dir = '0;
  logic [NE-1:0] evt_set = '0;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_idx = '0;
  logic [15:0] wr_data = '0;
  logic [4:0]  pin_out;
  logic [19:0] slot12;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_evt_status #(.NEVT(NE)) u_gpio_evt_status (
    .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe), .ctl_slot12(ctl_slot12),
    .pin_in(pin_in), .pin_dir(pin_dir), .evt_set(evt_set), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .pin_out(pin_out), .slot12(slot12)
  );

  // Bench model, written from the requirements
  logic [4:0]  m_s1, m_s2, m_s3, m_wake, m_pstat, m_out, m_echo;
  logic [NE-1:0] m_cfg, m_estat;

  function automatic logic [19:0] exp_word(input logic [4:0] dir);
    logic [19:0] w;
    logic [4:0] g;
    logic sum;
    g = 5'd0;
    for (int i = 0; i < 5; i++) g[i] = dir[i] ? m_echo[i] : m_s2[i];
    sum = (m_estat & m_cfg) != '0;
    w = 20'd0;
    for (int i = 0; i < 5; i++) w[4 + i] = g[i];
    w[2] = sum;
    w[0] = sum | ((m_pstat & m_wake) != 5'd0);
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_s1 = 0; m_s2 = 0; m_s3 = 0; m_wake = 0; m_pstat = 0;
    m_out = 0; m_echo = 0; m_cfg = 0; m_estat = 0;
  endtask

  task automatic compare_all();
    logic [19:0] e;
    e = exp_word(pin_dir);
    check(slot12[8:4] == e[8:4], "R2/R3 gpio field", {15'd0, slot12[8:4]}, {15'd0, e[8:4]});
    check(slot12[19:9] == 0 && !slot12[3] && !slot12[1], "R1 reserved", slot12, e & 20'h00115);
    check(slot12[2] == e[2], "R7 summary", {19'd0, slot12[2]}, {19'd0, e[2]});
    check(slot12[0] == e[0], "R8 irq", {19'd0, slot12[0]}, {19'd0, e[0]});
    check(pin_out == m_out, "R3 pin_out", {15'd0, pin_out}, {15'd0, m_out});
  endtask

  // Inputs are set before the call; one edge, model update, compare, clear pulses
  task automatic tick();
    logic [4:0] set;
    @(posedge clk);
    set = (m_s2 ^ m_s3) & ~pin_dir & m_wake;
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    if (wr_en && wr_idx == 7'h54) m_pstat = m_pstat & wr_data[4:0];
    m_pstat = m_pstat | set;
    if (wr_en && wr_idx == 7'h7A) m_estat = m_estat & wr_data;
    m_estat = m_estat | evt_set;
    if (wr_en && wr_idx == 7'h52) m_wake = wr_data[4:0];
    if (wr_en && wr_idx == 7'h70) m_cfg = wr_data;
    if (frame_strobe) begin m_echo = m_out; m_out = ctl_slot12[8:4]; end
    @(negedge clk);
    compare_all();
    wr_en = 0; evt_set = '0; frame_strobe = 0;
  endtask

  task automatic wr(input logic [6:0] idx, input logic [15:0] d);
    wr_en = 1; wr_idx = idx; wr_data = d;
    tick();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(negedge clk);
    // R10: reset values
    check(slot12 == 0, "R10 slot12 after reset", slot12, 20'd0);
    check(pin_out == 0, "R10 pin_out after reset", {15'd0, pin_out}, 20'd0);
    rst_n = 1;
    idle(2);

    // R4: a change on a masked pin latches nothing
    pin_in = 5'b00001; idle(5);
    wr(7'h52, 16'h001F);
    check(slot12[0] == 0, "R4 masked change no status", {19'd0, slot12[0]}, 20'd0);
    // R4: an unmasked change latches status
    pin_in = 5'b00000; idle(4);
    check(slot12[0] == 1, "R4 unmasked change sets irq", {19'd0, slot12[0]}, 20'd1);

    // R9: a write to an unused index changes nothing
    wr(7'h55, 16'h0000);
    wr(7'h53, 16'h0000);
    check(slot12[0] == 1, "R9 unused index keeps status", {19'd0, slot12[0]}, 20'd1);

    // R5: a set and a clear of pin 1 in the same cycle
    pin_in = 5'b00010; tick(); tick();
    wr(7'h54, 16'h0000);
    check(slot12[0] == 1, "R5 set wins over clear", {19'd0, slot12[0]}, 20'd1);
    wr(7'h54, 16'h001F);
    check(slot12[0] == 1, "R5 write one keeps", {19'd0, slot12[0]}, 20'd1);
    wr(7'h54, 16'h0000);
    check(slot12[0] == 0, "R5 write zero clears", {19'd0, slot12[0]}, 20'd0);

    // R6/R7: a set and a clear of an event bit in the same cycle
    wr(7'h70, 16'hFFFF);
    evt_set = 16'h0008; wr(7'h7A, 16'h0000);
    check(slot12[2] == 1, "R6 event set wins", {19'd0, slot12[2]}, 20'd1);
    wr(7'h70, 16'hFFF7);
    check(slot12[2] == 0, "R7 disabled event hidden", {19'd0, slot12[2]}, 20'd0);
    wr(7'h70, 16'hFFFF);
    wr(7'h7A, 16'hFFF7);
    check(slot12[0] == 0, "R8 irq drops when all cleared", {19'd0, slot12[0]}, 20'd0);

    // R3: output loop-back trails by one frame
    pin_dir = 5'b11111;
    ctl_slot12 = 20'h000A0; frame_strobe = 1; tick();
    check(pin_out == 5'b01010, "R3 pin_out loads", {15'd0, pin_out}, 20'h0000A);
    check(slot12[8:4] == 5'b00000, "R3 echo not yet", {15'd0, slot12[8:4]}, 20'd0);
    ctl_slot12 = 20'h00150; frame_strobe = 1; tick();
    check(slot12[8:4] == 5'b01010, "R3 echo next frame", {15'd0, slot12[8:4]}, 20'h0000A);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      r = $urandom % 100;
      if (i % 500 == 0) pin_dir = 5'($urandom);
      if (r < 20) pin_in = pin_in ^ 5'(1 << ($urandom % 5));
      if (($urandom % 7) == 0) begin frame_strobe = 1; ctl_slot12 = 20'($urandom); end
      if (($urandom % 9) == 0) evt_set = NE'(1 << ($urandom % NE));
      if (($urandom % 6) == 0) begin
        int unsigned k;
        k = $urandom % 5;
        wr_en = 1;
        wr_data = 16'($urandom);
        case (k)
          0: wr_idx = 7'h52;
          1: wr_idx = 7'h54;
          2: wr_idx = 7'h70;
          3: wr_idx = 7'h7A;
          default: wr_idx = 7'h60;
        endcase
      end
      tick();
    end

    finish_run();
  end
endmodule